// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one accepted burst request into the column address for every data beat of an SDRAM-style access. It decodes a 13-bit programmed mode word to find the burst length, the ordering within an aligned block, the CAS latency and whether writes are reduced to one location. It then steps through the columns, one beat per cycle in which the advance strobe is high. Finite bursts of 2, 4 or 8 beats stay inside their aligned block. A full-page burst walks the whole 1,024-column row and runs until it is terminated.

A controller pulses `start_i` with the mode word, the starting column and the access direction. The first beat appears on `col_o` one cycle later, with `valid_o` high. The controller raises `adv_i` on each cycle in which it consumes a beat. `last_o` marks the final beat of a finite burst. Mode words that use reserved encodings are refused. A refused request issues no beats and raises `err_o` for one cycle.

Top module: `sdcol_gen`

## Requirements
- R1: The burst length comes from mode bits [2:0]. 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives a full-page burst.
- R2: With mode bit 3 = 0 (sequential), the beat k column offset is (start offset + k) modulo the block size, so length 4 from offset 2 gives offsets 2,3,0,1.
- R3: With mode bit 3 = 1 (interleaved), the beat k offset is the start offset XOR k, so length 8 from offset 5 gives 5,4,7,6,1,0,3,2. For a one-beat burst, mode bit 3 has no effect.
- R4: During a finite burst, the column bits above the block offset keep the value of the start column on every beat.
- R5: A full-page burst accepts only sequential order. It starts at the given column and adds 1 per advance, wrapping from 1023 to 0. It never raises `last_o`. It ends one cycle after `stop_i` is sampled high. For finite bursts, `stop_i` is ignored.
- R6: `last_o` is high exactly on the final beat of a finite burst. An advance on that beat drops `valid_o` on the next cycle.
- R7: A start is refused when any of the following holds: the length code is reserved (100, 101 or 110); the length is full page with interleaved order; CAS bits [6:4] are neither 010 nor 011; or bits [8:7] are not 00. A refused start sets `err_o` for exactly the next cycle, issues no beats and leaves a running burst unchanged. Bits [12:10] are ignored.
- R8: If mode bit 9 = 1 and `wr_i` = 1, the burst is one beat long. A read burst with bit 9 = 1 uses the programmed length.
- R9: A beat advances only on cycles with `adv_i` high. Otherwise `col_o` holds its value.
- R10: An accepted start during a running burst restarts it. The first beat is the new start column, one cycle later. A start takes priority over advance and stop.
- R11: `cas_lat_o` gives the CAS latency (2 or 3) of the last accepted mode word, from one cycle after its start.
- R12: After reset, `valid_o`, `last_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 13 | Programmed mode word, sampled with a start |
| start_i | input | 1 | Burst request pulse |
| col_i | input | 10 | Starting column |
| wr_i | input | 1 | 1 for a write burst |
| adv_i | input | 1 | Consume the current beat |
| stop_i | input | 1 | Terminate a full-page burst |
| col_o | output | 10 | Column address of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Current beat is the last of a finite burst |
| err_o | output | 1 | Previous cycle's start was refused |
| cas_lat_o | output | 2 | CAS latency of the accepted mode word |

## Verification
The assertions assume the following about the inputs:
- The environment applies `mode_i`, `col_i` and `wr_i` only together with a start pulse, and treats them as don't-care otherwise.
- `stop_i` means something only while a full-page burst runs.
- `start_i` is held low during reset, so no past-value check sees a request from before reset.

The stimulus keeps to these assumptions in two ways. It changes every input only on falling edges. It pulses `start_i` for a single cycle with the full request presented at once, including the restart and refused-start cases that deliberately overlap a running burst.

// File: rtl/sdcol_pkg.sv
package sdcol_pkg;

  // mode word field positions; a neighbouring controller decodes the same word
  localparam int unsigned BL_LSB = 0;
  localparam int unsigned BT_BIT = 3;
  localparam int unsigned CL_LSB = 4;
  localparam int unsigned OP_LSB = 7;
  localparam int unsigned WB_BIT = 9;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_INT = 1'b1
  } order_e;

  typedef struct packed {
    logic       legal;
    logic       full;
    order_e     order;
    logic [1:0] len_log;
    logic [1:0] cas;
    logic       wr_single;
  } mode_dec_t;

endpackage

// File: rtl/sdcol_mode_dec.sv
module sdcol_mode_dec
  import sdcol_pkg::*;
#(
  parameter int unsigned MODE_W = 13
) (
  input  logic [MODE_W-1:0] mode_i,
  output mode_dec_t         dec_o
);

  logic bl_ok, cl_ok, op_ok;
  logic unused_rsvd;

  // upper reserved bits carry no meaning here
  assign unused_rsvd = ^mode_i[MODE_W-1:WB_BIT+1];

  always_comb begin
    dec_o   = '0;
    bl_ok   = 1'b1;
    cl_ok   = 1'b1;
    case (mode_i[BL_LSB+:3])
      3'b000:  dec_o.len_log = 2'd0;
      3'b001:  dec_o.len_log = 2'd1;
      3'b010:  dec_o.len_log = 2'd2;
      3'b011:  dec_o.len_log = 2'd3;
      3'b111:  dec_o.full    = 1'b1;
      default: bl_ok         = 1'b0;
    endcase
    case (mode_i[CL_LSB+:3])
      3'b010:  dec_o.cas = 2'd2;
      3'b011:  dec_o.cas = 2'd3;
      default: cl_ok     = 1'b0;
    endcase
    op_ok = (mode_i[OP_LSB+:2] == 2'b00);
    // order is meaningless for a single beat
    dec_o.order = (dec_o.len_log == 2'd0 && !dec_o.full) ? ORD_SEQ : order_e'(mode_i[BT_BIT]);
    dec_o.wr_single = mode_i[WB_BIT];
    dec_o.legal = bl_ok && cl_ok && op_ok && !(dec_o.full && mode_i[BT_BIT]);
  end

endmodule

// File: rtl/sdcol_addr_map.sv
module sdcol_addr_map
  import sdcol_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [1:0]       len_log_i,
  input  logic             full_i,
  input  order_e           order_i,
  output logic [COL_W-1:0] mask_o,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] sum, mix, walk;

  assign mask_o = ~({COL_W{1'b1}} << len_log_i);
  assign sum    = base_i + beat_i;
  assign mix    = base_i ^ beat_i;

  // per-bit select: block bits follow the order, upper bits keep the base
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign walk[b] = mask_o[b] ? ((order_i == ORD_INT) ? mix[b] : sum[b]) : base_i[b];
  end

  assign col_o = full_i ? sum : walk;

endmodule

// File: rtl/sdcol_gen.sv
module sdcol_gen
  import sdcol_pkg::*;
#(
  parameter int unsigned COL_W  = 10,
  parameter int unsigned MODE_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              start_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              wr_i,
  input  logic              adv_i,
  input  logic              stop_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              last_o,
  output logic              err_o,
  output logic [1:0]        cas_lat_o
);

  mode_dec_t        dec;
  logic             start_ok, single;
  logic             active_q, full_q, err_q;
  order_e           order_q;
  logic [1:0]       len_log_q, cas_q;
  logic [COL_W-1:0] base_q, beat_q, mask;
  logic             last_beat;

  sdcol_mode_dec #(.MODE_W(MODE_W)) u_dec (
    .mode_i (mode_i),
    .dec_o  (dec)
  );

  assign start_ok = start_i && dec.legal;
  assign single   = wr_i && dec.wr_single;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      full_q    <= 1'b0;
      err_q     <= 1'b0;
      order_q   <= ORD_SEQ;
      len_log_q <= '0;
      cas_q     <= 2'd2;
      base_q    <= '0;
      beat_q    <= '0;
    end else begin
      err_q <= start_i && !dec.legal;
      if (start_ok) begin
        active_q  <= 1'b1;
        base_q    <= col_i;
        beat_q    <= '0;
        cas_q     <= dec.cas;
        full_q    <= dec.full && !single;
        len_log_q <= single ? 2'd0 : dec.len_log;
        order_q   <= single ? ORD_SEQ : dec.order;
      end else if (active_q) begin
        if (full_q && stop_i) begin
          active_q <= 1'b0;
        end else if (adv_i) begin
          if (last_beat) active_q <= 1'b0;
          else           beat_q   <= beat_q + 1'b1;
        end
      end
    end
  end

  sdcol_addr_map #(.COL_W(COL_W)) u_map (
    .base_i    (base_q),
    .beat_i    (beat_q),
    .len_log_i (len_log_q),
    .full_i    (full_q),
    .order_i   (order_q),
    .mask_o    (mask),
    .col_o     (col_o)
  );

  assign last_beat = active_q && !full_q && (beat_q == mask);
  assign valid_o   = active_q;
  assign last_o    = last_beat;
  assign err_o     = err_q;
  assign cas_lat_o = cas_q;

  // R4
  blk_upper_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o) && !$past(start_i) && !full_q)
      |-> ((col_o & ~mask) == ($past(col_o) & ~mask)));

  // R5
  full_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o) && full_q && $past(adv_i) && !$past(start_i) && !$past(stop_i))
      |-> (col_o == COL_W'($past(col_o) + 1'b1)));

  // R6
  last_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && adv_i && !start_i) |=> !valid_o);

  // R7
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(start_i));

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o) && !$past(adv_i) && !$past(start_i)) |-> $stable(col_o));

  // R10
  begin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(start_i));

endmodule

// File: tb/sim_sdcol_gen.sv
`timescale 1ns/1ps
module sim_sdcol_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] mode_i = '0;
  logic        start_i = 1'b0;
  logic [9:0]  col_i = '0;
  logic        wr_i = 1'b0, adv_i = 1'b0, stop_i = 1'b0;
  logic [9:0]  col_o;
  logic        valid_o, last_o, err_o;
  logic [1:0]  cas_lat_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdcol_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode_i), .start_i(start_i),
    .col_i(col_i), .wr_i(wr_i), .adv_i(adv_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o),
    .cas_lat_o(cas_lat_o)
  );

  typedef struct packed {
    logic [12:0]     mode;
    logic [9:0]      col;
    logic            wr;
    logic [3:0]      len;
    logic [1:0]      cas;
    logic [2:0]      tag;
    logic [0:7][9:0] exp;
  } vec_t;

  // mode = {rsvd[2:0], wb, op[1:0], cas[2:0], bt, bl[2:0]}
  localparam vec_t VECS [11] = '{
    '{{3'b000,1'b0,2'b00,3'b010,1'b0,3'b010}, 10'd6,    1'b0, 4'd4, 2'd2, 3'd2, '{10'd6,10'd7,10'd4,10'd5,10'd0,10'd0,10'd0,10'd0}},
    '{{3'b000,1'b0,2'b00,3'b010,1'b1,3'b011}, 10'd13,   1'b0, 4'd8, 2'd2, 3'd3, '{10'd13,10'd12,10'd15,10'd14,10'd9,10'd8,10'd11,10'd10}},
    '{{3'b000,1'b0,2'b00,3'b011,1'b0,3'b011}, 10'd1021, 1'b0, 4'd8, 2'd3, 3'd4, '{10'd1021,10'd1022,10'd1023,10'd1016,10'd1017,10'd1018,10'd1019,10'd1020}},
    '{{3'b000,1'b0,2'b00,3'b010,1'b1,3'b001}, 10'd3,    1'b0, 4'd2, 2'd2, 3'd3, '{10'd3,10'd2,10'd0,10'd0,10'd0,10'd0,10'd0,10'd0}},
    '{{3'b000,1'b0,2'b00,3'b011,1'b0,3'b001}, 10'd514,  1'b0, 4'd2, 2'd3, 3'd1, '{10'd514,10'd515,10'd0,10'd0,10'd0,10'd0,10'd0,10'd0}},
    '{{3'b000,1'b0,2'b00,3'b010,1'b1,3'b000}, 10'd777,  1'b0, 4'd1, 2'd2, 3'd3, '{10'd777,10'd0,10'd0,10'd0,10'd0,10'd0,10'd0,10'd0}},
    '{{3'b000,1'b0,2'b00,3'b011,1'b1,3'b010}, 10'd7,    1'b0, 4'd4, 2'd3, 3'd3, '{10'd7,10'd6,10'd5,10'd4,10'd0,10'd0,10'd0,10'd0}},
    '{{3'b000,1'b1,2'b00,3'b010,1'b0,3'b011}, 10'd100,  1'b1, 4'd1, 2'd2, 3'd5, '{10'd100,10'd0,10'd0,10'd0,10'd0,10'd0,10'd0,10'd0}},
    '{{3'b000,1'b0,2'b00,3'b010,1'b0,3'b010}, 10'd101,  1'b1, 4'd4, 2'd2, 3'd5, '{10'd101,10'd102,10'd103,10'd100,10'd0,10'd0,10'd0,10'd0}},
    '{{3'b111,1'b0,2'b00,3'b011,1'b0,3'b010}, 10'd0,    1'b0, 4'd4, 2'd3, 3'd6, '{10'd0,10'd1,10'd2,10'd3,10'd0,10'd0,10'd0,10'd0}},
    '{{3'b000,1'b1,2'b00,3'b010,1'b0,3'b001}, 10'd40,   1'b0, 4'd2, 2'd2, 3'd5, '{10'd40,10'd41,10'd0,10'd0,10'd0,10'd0,10'd0,10'd0}}
  };

  function automatic string tag_s(logic [2:0] t);
    case (t)
      3'd1: return "R1 R2";
      3'd2: return "R2 R4";
      3'd3: return "R3 R4";
      3'd4: return "R4 wrap";
      3'd5: return "R8";
      default: return "R7 upper bits";
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [12:0] mk(logic [2:0] cas, logic bt, logic [2:0] bl, logic [1:0] op);
    return {3'b000, 1'b0, op, cas, bt, bl};
  endfunction

  task automatic bad_start(logic [12:0] m, string req);
    @(negedge clk); mode_i = m; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk({req, " err set"}, err_o, 1);
    chk({req, " no beat"}, valid_o, 0);
    @(negedge clk);
    chk({req, " err one cycle"}, err_o, 0);
    chk({req, " still idle"}, valid_o, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12
    chk("R12 valid", valid_o, 0);
    chk("R12 last", last_o, 0);
    chk("R12 err", err_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 valid after release", valid_o, 0);

    for (int v = 0; v < 11; v++) begin
      @(negedge clk);
      mode_i = VECS[v].mode; col_i = VECS[v].col; wr_i = VECS[v].wr;
      start_i = 1'b1; adv_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      chk("R11 cas", cas_lat_o, VECS[v].cas);
      for (int b = 0; b < int'(VECS[v].len); b++) begin
        chk({tag_s(VECS[v].tag), " col"}, col_o, VECS[v].exp[b]);
        chk("R1 valid", valid_o, 1);
        chk("R6 last", last_o, (b == int'(VECS[v].len) - 1) ? 1 : 0);
        @(negedge clk);
      end
      chk("R6 ends", valid_o, 0);
    end
    adv_i = 1'b0; wr_i = 1'b0;

    // R7 refused encodings
    bad_start(mk(3'b010, 1'b0, 3'b100, 2'b00), "R7 bl reserved");
    bad_start(mk(3'b010, 1'b0, 3'b110, 2'b00), "R7 bl 110");
    bad_start(mk(3'b010, 1'b1, 3'b111, 2'b00), "R7 full interleaved");
    bad_start(mk(3'b001, 1'b0, 3'b010, 2'b00), "R7 cas 1");
    bad_start(mk(3'b100, 1'b0, 3'b010, 2'b00), "R7 cas 4");
    bad_start(mk(3'b010, 1'b0, 3'b010, 2'b10), "R7 op bits");

    // R5 full page with wrap, hold and stop
    @(negedge clk);
    mode_i = mk(3'b010, 1'b0, 3'b111, 2'b00); col_i = 10'd1022;
    start_i = 1'b1; adv_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk("R5 first", col_o, 1022); chk("R5 no last", last_o, 0);
    @(negedge clk); chk("R5 step", col_o, 1023);
    @(negedge clk); chk("R5 wrap", col_o, 0); chk("R5 no last wrap", last_o, 0);
    @(negedge clk); chk("R5 after wrap", col_o, 1);
    adv_i = 1'b0;
    @(negedge clk); chk("R9 full hold", col_o, 1); chk("R5 running", valid_o, 1);
    stop_i = 1'b1; adv_i = 1'b1;
    @(negedge clk); stop_i = 1'b0; adv_i = 1'b0;
    chk("R5 stopped", valid_o, 0);

    // R10 restart mid burst
    @(negedge clk);
    mode_i = mk(3'b010, 1'b0, 3'b011, 2'b00); col_i = 10'd0;
    start_i = 1'b1; adv_i = 1'b1;
    @(negedge clk); start_i = 1'b0; chk("R10 old beat0", col_o, 0);
    @(negedge clk); chk("R10 old beat1", col_o, 1);
    mode_i = mk(3'b011, 1'b0, 3'b010, 2'b00); col_i = 10'd20; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk("R10 restart col", col_o, 20); chk("R11 new cas", cas_lat_o, 3);
    @(negedge clk); chk("R10 next", col_o, 21);
    repeat (3) @(negedge clk);
    chk("R10 new length", valid_o, 0);

    // R7 refusal during a burst, R9 hold, R5 stop ignored for finite
    adv_i = 1'b0;
    mode_i = mk(3'b010, 1'b0, 3'b010, 2'b00); col_i = 10'd8; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0; chk("R9 beat0", col_o, 8);
    stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    chk("R9 held", col_o, 8); chk("R5 stop ignored finite", valid_o, 1);
    mode_i = mk(3'b000, 1'b0, 3'b010, 2'b00); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk("R7 err in burst", err_o, 1); chk("R7 burst kept", valid_o, 1);
    chk("R7 col kept", col_o, 8);
    adv_i = 1'b1;
    @(negedge clk); chk("R9 resumes", col_o, 9);
    repeat (3) @(negedge clk);
    chk("R6 finished", valid_o, 0);
    adv_i = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule